// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a physical access may go ahead. It holds a configurable number of protection entries. Each entry has a configuration byte, with read, write and execute permissions, a match mode and a lock bit, and an address register. Both are written through a simple CSR-style write port. Every load, store or instruction fetch presented on the request port is compared against all entries. The lowest-numbered entry that covers the address decides the outcome. A disallowed access raises the access-fault flag that matches its kind.

Regions are defined in three ways. In top-of-range mode, the previous entry's address and the entry's own address bound the region. In naturally aligned power-of-two mode, the trailing ones of the address register set the size. A single-granule mode matches one granule. All comparisons work on a 64-byte granule. For power-of-two matching, a per-entry ignore mask is held in a register and recomputed whenever that entry's configuration or address is written. A page fault already found by translation is passed through, but only when this check raises no access fault. A parameter selects one of two response timings: in the same cycle as the request, or from a register loaded one cycle later.

Top module: `prot_region_check`

## Requirements
- R1: After reset every entry is off and unlocked, and no response flag is asserted. A request from a non-machine requester then faults, and a machine-mode request is allowed.
- R2: The configuration byte has read in bit 0, write in bit 1, execute in bit 2, mode in bits 4:3 (0 off, 1 top-of-range, 2 single granule, 3 power-of-two) and lock in bit 7. The address register holds byte-address bits [AW-1:2].
- R3: An entry in top-of-range mode matches when the lower bound ≤ address < its own address×4. The lower bound is the previous entry's address×4, or 0 for entry 0. The comparison uses only address bits at and above bit 6.
- R4: An entry in power-of-two mode with k trailing ones in its address register covers 2^(k+3) bytes aligned to that size, but never less than 64 bytes. Its mask is refreshed when its configuration is written.
- R5: An entry in mode 2 matches exactly the 64-byte granule that contains its address×4.
- R6: When several entries match, the lowest-numbered one decides the result.
- R7: With no matching entry, machine mode is allowed and any other requester faults. A matching unlocked entry never restricts machine mode. A matching locked entry applies its permissions to machine mode too.
- R8: Request kind is 0 load, 1 store, 2 fetch (3 is treated as load). These are checked against the read, write and execute bits. A denied store raises only the store fault, a denied load only the load fault, and a denied fetch only the fetch fault.
- R9: An entry whose lock bit is set ignores later writes to its configuration and address until reset.
- R10: The page-fault output follows the page-fault input only when no access fault is raised for the same request.
- R11: With REG_RESP=1 the response appears one cycle after the request, with respValid. The fault flags are loaded only on request cycles and hold otherwise. With REG_RESP=0 the response appears in the same cycle, and all flags are low when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrIdx | input | IW | Entry index for configuration write |
| cfgWrData | input | 8 | Configuration byte to write |
| addrWrEn | input | 1 | Address register write strobe |
| addrWrIdx | input | IW | Entry index for address write |
| addrWrData | input | AW-2 | Address register value (byte address >> 2) |
| reqValid | input | 1 | Access request present |
| reqAddr | input | AW | Physical byte address |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch |
| reqMachine | input | 1 | Requester runs in machine mode |
| reqPageFault | input | 1 | Translation already found a page fault |
| respValid | output | 1 | Response present |
| respLoadFault | output | 1 | Load access fault |
| respStoreFault | output | 1 | Store access fault |
| respFetchFault | output | 1 | Fetch access fault |
| respPageFault | output | 1 | Page fault passed through |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the registered response (REG_RESP=1, the default) and one uses the same-cycle response (REG_RESP=0), both with 16 entries, 36-bit addresses and the 64-byte granule. This puts within reach the one-cycle offset, the hold of the registered flags across idle cycles, and the zeroed same-cycle flags when idle, with identical region decisions expected from both. The region set places overlapping entries, both region edges of top-of-range and power-of-two entries, a sub-granule power-of-two entry and a locked entry on which later writes are tried.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_GRAIN = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  localparam int CfgBitR    = 0;
  localparam int CfgBitW    = 1;
  localparam int CfgBitX    = 2;
  localparam int CfgModeLo  = 3;
  localparam int CfgModeHi  = 4;
  localparam int CfgBitLock = 7;

  typedef struct packed {
    logic cfgStb;
    logic addrStb;
    logic respEn;
  } prot_strobe_t;

endpackage

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          cfgWrEn,
  input  logic [IW-1:0] cfgWrIdx,
  input  logic          addrWrEn,
  input  logic [IW-1:0] addrWrIdx,
  input  logic [N-1:0]  lockVec,
  input  logic          reqValid,
  output prot_strobe_t  strobes
);

  logic cfgInRange;
  logic addrInRange;
  logic cfgLocked;
  logic addrLocked;

  always_comb begin
    cfgInRange  = 32'(cfgWrIdx) < N;
    addrInRange = 32'(addrWrIdx) < N;
    cfgLocked   = 1'b0;
    addrLocked  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (32'(cfgWrIdx) == i)  cfgLocked  = lockVec[i];
      if (32'(addrWrIdx) == i) addrLocked = lockVec[i];
    end
    strobes.cfgStb  = cfgWrEn && cfgInRange && !cfgLocked;
    strobes.addrStb = addrWrEn && addrInRange && !addrLocked;
    strobes.respEn  = reqValid;
  end

endmodule

// File: rtl/prot_datapath.sv
module prot_datapath
  import prot_pkg::*;
#(
  parameter int N        = 16,
  parameter int IW       = 4,
  parameter int AW       = 36,
  parameter int GRAIN    = 6,
  parameter bit REG_RESP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  prot_strobe_t  strobes,
  input  logic [IW-1:0] cfgWrIdx,
  input  logic [7:0]    cfgWrData,
  input  logic [IW-1:0] addrWrIdx,
  input  logic [AW-3:0] addrWrData,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqKind,
  input  logic          reqMachine,
  input  logic          reqPageFault,
  output logic [N-1:0]  lockVec,
  output logic          respValid,
  output logic          respLoadFault,
  output logic          respStoreFault,
  output logic          respFetchFault,
  output logic          respPageFault
);

  localparam int GW = AW - GRAIN;
  localparam logic [AW-1:0] GrainMask = AW'((64'd1 << GRAIN) - 64'd1);

  function automatic logic [AW-1:0] napotMask(input logic [AW-3:0] a);
    logic [AW-1:0] ext;
    ext = {a, 2'b11};
    return (ext ^ (ext + AW'(1))) | GrainMask;
  endfunction

  logic [N-1:0][7:0]    cfgAll;
  logic [N-1:0][AW-3:0] addrAll;
  logic [N-1:0]         hitVec;

  for (genvar i = 0; i < N; i++) begin : gEntry
    logic [7:0]    cfgQ;
    logic [AW-3:0] addrQ;
    logic [AW-1:0] maskQ;
    logic          cfgLoad;
    logic          addrLoad;
    logic [AW-1:0] base;
    logic [AW-1:0] lower;
    logic [1:0]    mode;
    logic          torHit;
    logic          napotHit;
    logic          grainHit;

    assign cfgLoad  = strobes.cfgStb && (32'(cfgWrIdx) == i);
    assign addrLoad = strobes.addrStb && (32'(addrWrIdx) == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfgQ  <= '0;
        addrQ <= '0;
        maskQ <= napotMask('0);
      end else begin
        if (cfgLoad)  cfgQ  <= cfgWrData;
        if (addrLoad) addrQ <= addrWrData;
        if (cfgLoad || addrLoad) maskQ <= napotMask(addrLoad ? addrWrData : addrQ);
      end
    end

    if (i == 0) begin : gLowZero
      assign lower = '0;
    end else begin : gLowPrev
      assign lower = {addrAll[i-1], 2'b00};
    end

    assign base     = {addrQ, 2'b00};
    assign mode     = cfgQ[CfgModeHi:CfgModeLo];
    assign torHit   = (reqAddr[AW-1:GRAIN] >= lower[AW-1:GRAIN]) &&
                      (reqAddr[AW-1:GRAIN] <  base[AW-1:GRAIN]);
    assign napotHit = ((reqAddr ^ base) & ~maskQ) == '0;
    assign grainHit = reqAddr[AW-1:GRAIN] == base[AW-1:GRAIN];

    always_comb begin
      unique case (mode)
        MODE_TOR:   hitVec[i] = torHit;
        MODE_GRAIN: hitVec[i] = grainHit;
        MODE_NAPOT: hitVec[i] = napotHit;
        default:    hitVec[i] = 1'b0;
      endcase
    end

    assign cfgAll[i]  = cfgQ;
    assign addrAll[i] = addrQ;
    assign lockVec[i] = cfgQ[CfgBitLock];
  end

  logic          hitAny;
  logic [7:0]    hitCfg;
  logic          permOk;
  logic          allowed;
  logic          nxtLoad;
  logic          nxtStore;
  logic          nxtFetch;
  logic          nxtPage;
  logic [GW-1:0] unusedGw;

  assign unusedGw = '0;

  always_comb begin
    hitAny = 1'b0;
    hitCfg = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitCfg = cfgAll[i];
      end
    end
    unique case (reqKind)
      KIND_STORE: permOk = hitCfg[CfgBitW];
      KIND_FETCH: permOk = hitCfg[CfgBitX];
      default:    permOk = hitCfg[CfgBitR];
    endcase
    if (hitAny) allowed = (reqMachine && !hitCfg[CfgBitLock]) || permOk;
    else        allowed = reqMachine;
    nxtStore = reqValid && !allowed && (reqKind == KIND_STORE);
    nxtFetch = reqValid && !allowed && (reqKind == KIND_FETCH);
    nxtLoad  = reqValid && !allowed && (reqKind != KIND_STORE) && (reqKind != KIND_FETCH);
    nxtPage  = reqValid && allowed && reqPageFault;
  end

  if (REG_RESP) begin : gRegResp
    always_ff @(posedge clk) begin
      if (rst) begin
        respValid      <= 1'b0;
        respLoadFault  <= 1'b0;
        respStoreFault <= 1'b0;
        respFetchFault <= 1'b0;
        respPageFault  <= 1'b0;
      end else begin
        respValid <= reqValid;
        if (strobes.respEn) begin
          respLoadFault  <= nxtLoad;
          respStoreFault <= nxtStore;
          respFetchFault <= nxtFetch;
          respPageFault  <= nxtPage;
        end
      end
    end
  end else begin : gCombResp
    assign respValid      = reqValid;
    assign respLoadFault  = nxtLoad;
    assign respStoreFault = nxtStore;
    assign respFetchFault = nxtFetch;
    assign respPageFault  = nxtPage;
  end

endmodule

// File: rtl/prot_region_check.sv
module prot_region_check
  import prot_pkg::*;
#(
  parameter int N        = 16,
  parameter int AW       = 36,
  parameter int GRAIN    = 6,
  parameter bit REG_RESP = 1'b1,
  localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfgWrEn,
  input  logic [IW-1:0] cfgWrIdx,
  input  logic [7:0]    cfgWrData,
  input  logic          addrWrEn,
  input  logic [IW-1:0] addrWrIdx,
  input  logic [AW-3:0] addrWrData,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqKind,
  input  logic          reqMachine,
  input  logic          reqPageFault,
  output logic          respValid,
  output logic          respLoadFault,
  output logic          respStoreFault,
  output logic          respFetchFault,
  output logic          respPageFault
);

  prot_strobe_t strobes;
  logic [N-1:0] lockVec;

  prot_ctrl #(.N(N), .IW(IW)) uCtrl (
    .cfgWrEn  (cfgWrEn),
    .cfgWrIdx (cfgWrIdx),
    .addrWrEn (addrWrEn),
    .addrWrIdx(addrWrIdx),
    .lockVec  (lockVec),
    .reqValid (reqValid),
    .strobes  (strobes)
  );

  prot_datapath #(.N(N), .IW(IW), .AW(AW), .GRAIN(GRAIN), .REG_RESP(REG_RESP)) uData (
    .clk           (clk),
    .rst           (rst),
    .strobes       (strobes),
    .cfgWrIdx      (cfgWrIdx),
    .cfgWrData     (cfgWrData),
    .addrWrIdx     (addrWrIdx),
    .addrWrData    (addrWrData),
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .reqKind       (reqKind),
    .reqMachine    (reqMachine),
    .reqPageFault  (reqPageFault),
    .lockVec       (lockVec),
    .respValid     (respValid),
    .respLoadFault (respLoadFault),
    .respStoreFault(respStoreFault),
    .respFetchFault(respFetchFault),
    .respPageFault (respPageFault)
  );

endmodule

// File: rtl/prot_region_check_sva.sv
module prot_region_check_sva #(
  parameter int AW       = 36,
  parameter bit REG_RESP = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          reqValid,
  input logic [1:0]    reqKind,
  input logic          respValid,
  input logic          respLoadFault,
  input logic          respStoreFault,
  input logic          respFetchFault,
  input logic          respPageFault
);

  // R8: at most one access-fault flag at a time
  a_r8_one_fault: assert property (@(posedge clk) disable iff (rst)
    $onehot0({respLoadFault, respStoreFault, respFetchFault}));

  // R10: page fault never reported together with an access fault
  a_r10_pf_yields: assert property (@(posedge clk) disable iff (rst)
    respPageFault |-> !(respLoadFault || respStoreFault || respFetchFault));

  if (REG_RESP) begin : gRegChk
    // R11: registered response follows request by one cycle
    a_r11_valid_late: assert property (@(posedge clk) disable iff (rst)
      reqValid |=> respValid);
    a_r11_idle_late: assert property (@(posedge clk) disable iff (rst)
      !reqValid |=> !respValid);
    // R11: flags hold across idle cycles
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !reqValid |=> $stable({respLoadFault, respStoreFault, respFetchFault, respPageFault}));
    // R8: a store fault only answers a store request
    a_r8_store_kind: assert property (@(posedge clk) disable iff (rst)
      (reqValid && reqKind != 2'd1) |=> !respStoreFault);
  end else begin : gCombChk
    // R11: same-cycle response is quiet when idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !reqValid |-> !(respValid || respLoadFault || respStoreFault || respFetchFault || respPageFault));
    // R8: a store fault only answers a store request
    a_r8_store_kind: assert property (@(posedge clk) disable iff (rst)
      respStoreFault |-> (reqValid && reqKind == 2'd1));
  end

endmodule

bind prot_region_check prot_region_check_sva #(.AW(AW), .REG_RESP(REG_RESP)) uChk (.*);

// File: tb/tb_prot_region_check.sv
`timescale 1ns/1ps
module tb_prot_region_check;

  localparam int N  = 16;
  localparam int AW = 36;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfgWrEn = 1'b0;
  logic [IW-1:0] cfgWrIdx = '0;
  logic [7:0]    cfgWrData = '0;
  logic          addrWrEn = 1'b0;
  logic [IW-1:0] addrWrIdx = '0;
  logic [AW-3:0] addrWrData = '0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqKind = '0;
  logic          reqMachine = 1'b0;
  logic          reqPageFault = 1'b0;

  logic rV, rL, rS, rF, rP;
  logic cV, cL, cS, cF, cP;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prot_region_check #(.N(N), .AW(AW), .REG_RESP(1'b1)) dut (
    .clk(clk), .rst(rst),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData),
    .addrWrEn(addrWrEn), .addrWrIdx(addrWrIdx), .addrWrData(addrWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqMachine(reqMachine), .reqPageFault(reqPageFault),
    .respValid(rV), .respLoadFault(rL), .respStoreFault(rS),
    .respFetchFault(rF), .respPageFault(rP)
  );

  prot_region_check #(.N(N), .AW(AW), .REG_RESP(1'b0)) dutComb (
    .clk(clk), .rst(rst),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData),
    .addrWrEn(addrWrEn), .addrWrIdx(addrWrIdx), .addrWrData(addrWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind),
    .reqMachine(reqMachine), .reqPageFault(reqPageFault),
    .respValid(cV), .respLoadFault(cL), .respStoreFault(cS),
    .respFetchFault(cF), .respPageFault(cP)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (valid,load,store,fetch,page)", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input int idx, input logic [7:0] data);
    cfgWrEn = 1'b1; cfgWrIdx = IW'(idx); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic wrAddr(input int idx, input logic [AW-3:0] data);
    addrWrEn = 1'b1; addrWrIdx = IW'(idx); addrWrData = data;
    @(negedge clk);
    addrWrEn = 1'b0;
  endtask

  // Drive one request at a falling edge; check same-cycle copy mid-cycle,
  // registered copy at the next falling edge.
  task automatic doReq(input string tag, input logic [AW-1:0] a, input logic [1:0] kind,
                       input logic mach, input logic pf, input logic expFault);
    logic [4:0] exp;
    exp[4] = 1'b1;
    exp[3] = expFault && (kind != 2'd1) && (kind != 2'd2);
    exp[2] = expFault && (kind == 2'd1);
    exp[1] = expFault && (kind == 2'd2);
    exp[0] = !expFault && pf;
    reqValid = 1'b1; reqAddr = a; reqKind = kind; reqMachine = mach; reqPageFault = pf;
    #5;
    chk({tag, " comb"}, {cV, cL, cS, cF, cP}, exp);
    @(negedge clk);
    chk({tag, " reg"}, {rV, rL, rS, rF, rP}, exp);
    reqValid = 1'b0; reqPageFault = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 reset reg outputs", {rV, rL, rS, rF, rP}, 5'b0);
    chk("R1 reset comb outputs", {cV, cL, cS, cF, cP}, 5'b0);
    doReq("R1 user load no entry", 36'h100, 2'd0, 1'b0, 1'b0, 1'b1);
    doReq("R1 R7 machine load no entry", 36'h100, 2'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testTor();
    wrAddr(0, 34'(36'h2000 >> 2));
    wrCfg(0, 8'h09);
    doReq("R3 tor bottom granule", 36'h1FC0, 2'd0, 1'b0, 1'b0, 1'b0);
    doReq("R3 tor top byte inside", 36'h1FFF, 2'd0, 1'b0, 1'b0, 1'b0);
    doReq("R3 tor upper exclusive", 36'h2000, 2'd0, 1'b0, 1'b0, 1'b1);
    doReq("R8 R2 store without write", 36'h100, 2'd1, 1'b0, 1'b0, 1'b1);
    doReq("R8 fetch without execute", 36'h100, 2'd2, 1'b0, 1'b0, 1'b1);
    doReq("R8 kind 3 as load", 36'h100, 2'd3, 1'b0, 1'b0, 1'b0);
    wrAddr(1, 34'(36'h3000 >> 2));
    wrCfg(1, 8'h0B);
    doReq("R3 tor lower from previous", 36'h2000, 2'd1, 1'b0, 1'b0, 1'b0);
    doReq("R3 tor second upper", 36'h3000, 2'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testNapot();
    wrAddr(2, 34'h41FF);
    wrCfg(2, 8'h1C);
    doReq("R4 napot last word", 36'h10FFC, 2'd2, 1'b0, 1'b0, 1'b0);
    doReq("R4 napot above", 36'h11000, 2'd2, 1'b0, 1'b0, 1'b1);
    doReq("R4 napot below", 36'h0FFFC, 2'd2, 1'b0, 1'b0, 1'b1);
    wrAddr(3, 34'h8000);
    wrCfg(3, 8'h19);
    doReq("R4 napot min granule inside", 36'h2003C, 2'd0, 1'b0, 1'b0, 1'b0);
    doReq("R4 napot min granule outside", 36'h20040, 2'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testGrain();
    wrAddr(4, 34'hC008);
    wrCfg(4, 8'h11);
    doReq("R5 granule start", 36'h30000, 2'd0, 1'b0, 1'b0, 1'b0);
    doReq("R5 next granule", 36'h30040, 2'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testPriority();
    wrAddr(5, 34'h41FF);
    wrCfg(5, 8'h1F);
    doReq("R6 lower entry denies load", 36'h10010, 2'd0, 1'b0, 1'b0, 1'b1);
    doReq("R6 lower entry allows fetch", 36'h10010, 2'd2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testMachineLock();
    doReq("R7 machine over unlocked", 36'h10010, 2'd0, 1'b1, 1'b0, 1'b0);
    doReq("R7 machine no match", 36'h50000, 2'd1, 1'b1, 1'b0, 1'b0);
    wrAddr(6, 34'h18007);
    wrCfg(6, 8'h98);
    doReq("R7 machine locked entry", 36'h60000, 2'd0, 1'b1, 1'b0, 1'b1);
    wrCfg(6, 8'h1F);
    doReq("R9 cfg write ignored", 36'h60000, 2'd0, 1'b0, 1'b0, 1'b1);
    wrAddr(6, 34'h1C007);
    doReq("R9 addr write ignored new", 36'h70000, 2'd0, 1'b1, 1'b0, 1'b0);
    doReq("R9 addr write ignored old", 36'h60020, 2'd0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testPageFault();
    doReq("R10 page fault passes", 36'h1FC0, 2'd0, 1'b0, 1'b1, 1'b0);
    doReq("R10 access fault wins", 36'h50000, 2'd0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testTiming();
    doReq("R11 fault request", 36'h50000, 2'd1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R11 reg holds flags when idle", {rV, rL, rS, rF, rP}, 5'b00100);
    chk("R11 comb quiet when idle", {cV, cL, cS, cF, cP}, 5'b00000);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testTor();
    testNapot();
    testGrain();
    testPriority();
    testMachineLock();
    testPageFault();
    testTiming();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule